// File: doc/BRIEF.md
# Multi-Channel Standalone BIST Checker

This block sits on the receive side of a six-channel deserializer and runs an at-speed bit-error test on the recovered 10-bit words. The test can cover one selected channel or all six. Channels that are not selected keep carrying live traffic. Each channel under test compares its incoming words with a locally generated PRBS-15 sequence. It then replaces its data output with an error report and holds its lock indicator in the locked state.

The test is started and stopped by a level input that is filtered against short glitches. A select code picks the channel or channels to test. A report-mode input chooses how errors are shown: either a sticky all-ones flag per channel, or a flag for each bit of each word. Each channel also keeps a "run finished" bit and a "no errors seen" bit. Both bits are packed into a 12-bit vector that a scan data register can capture.

Words flow in on a valid strobe and flow out on a registered valid strobe. There is no ready signal, so the block never applies back-pressure. Every word presented with valid high is taken in the cycle it appears, and the downstream side must accept every output word.

Top module: `bist_multi_chk`

## Requirements
- R1: The internal test-active state changes only after `bist_act` has been sampled at the new level on 4 consecutive rising clock edges. A pulse or dropout lasting 3 cycles or fewer changes nothing.
- R2: While test-active is off, no channel is under test, whatever the value of `bist_sel`.
- R3: A channel not under test copies its data word and lock indicator to its outputs one clock later. Every channel copies its valid strobe to its output one clock later.
- R4: A channel under test drives its `tx_lock_n` bit low (low means locked) one clock after each cycle it is under test.
- R5: The reference is x^15 + x^14 + 1. Word bit 0 is the earliest bit of the sequence and bit 9 is the latest. The first two valid words after a channel enters test load the reference and are not compared, so the report for them is zero.
- R6: Gross mode (`rpt_bitmode` = 0): the channel's output is all zeros until a compared word mismatches. From that word's output cycle onward it is all ones, every cycle, until the channel leaves test.
- R7: Bit mode (`rpt_bitmode` = 1): for each compared word, output bit k is 1 exactly when received bit k differs from the reference. The output is zero in cycles that carry no compared word.
- R8: The complete bit of a channel sets on the edge of its RUN_WORDS-th compared word. Its pass bit is set at the same edge only if none of those words had an error. Later errors do not change either bit.
- R9: `bist_status` bit 2i+1 is channel i's complete bit and bit 2i is its pass bit, so channel 5's pair occupies bits 11:10.
- R10: The status bits of a channel keep their values after test stops. Both bits clear on the first clock edge at which the channel is under test again.
- R11: During reset all `tx_lock_n` bits are 1, and all data outputs, valid outputs and status bits are 0.
- R12: With test active, `bist_sel` codes 0 to 5 put only that channel under test, code 6 puts all six under test, and code 7 puts none under test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_act | input | 1 | Test activate level (glitch filtered) |
| bist_sel | input | 3 | Channel select code |
| rpt_bitmode | input | 1 | 0 = gross report, 1 = per-bit report |
| rx_data | input | 60 | Six received words, channel i at bits 10i+9:10i |
| rx_vld | input | 6 | Per-channel word valid |
| rx_lock_n | input | 6 | Per-channel lock indicator, low = locked |
| tx_data | output | 60 | Forwarded words or error reports |
| tx_vld | output | 6 | Registered valid strobes |
| tx_lock_n | output | 6 | Forwarded or forced lock indicators |
| bist_status | output | 12 | Packed complete/pass pairs |

## Verification
Data, valid and lock outputs are due one clock after the edge that samples the input. Test-active takes effect on the fourth qualifying edge, and the first word tested is the one sampled on the edge after that. Deactivation likewise takes effect on the fourth edge, and pass-through returns one edge later. Status bits change on the edge of the last compared word, and clear on the first edge a channel is under test. The bench drives inputs one time unit after a rising edge and reads the results one time unit after the next rising edge. Its cycle counts for the filter and for status are derived from these latencies.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;
  // Reference sequence: x^15 + x^14 + 1
  localparam int PRBS_DEG = 15;
  localparam int PRBS_TAP = 14;

  typedef enum logic {
    RPT_GROSS = 1'b0,
    RPT_BITS  = 1'b1
  } rpt_mode_e;
endpackage

// File: rtl/bist_act_filter.sv
module bist_act_filter #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_raw,
  output logic act_on
);
  localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;

  logic [CW-1:0] run_cnt;

  // The state flips only after DEB consecutive samples at the opposite level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_on  <= 1'b0;
      run_cnt <= '0;
    end else if (act_raw == act_on) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(DEB - 1)) begin
      act_on  <= act_raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/bist_sel_decode.sv
module bist_sel_decode #(
  parameter int NCH   = 6,
  parameter int SEL_W = 3
) (
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic [NCH-1:0]   lane_mask
);
  // Codes below NCH pick one lane, code NCH picks all lanes, and any higher code is idle.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lane_mask[i] = active && ((sel == SEL_W'(i)) || (sel == SEL_W'(NCH)));
    end
  end
endmodule

// File: rtl/bist_lane.sv
module bist_lane
  import bist_chk_pkg::*;
#(
  parameter int W         = 10,
  parameter int RUN_WORDS = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_test,
  input  logic         rpt_bitmode,
  input  logic [W-1:0] rx_data,
  input  logic         rx_vld,
  input  logic         rx_lock_n,
  output logic [W-1:0] tx_data,
  output logic         tx_vld,
  output logic         tx_lock_n,
  output logic         run_done,
  output logic         run_pass
);
  localparam int PRIME_WORDS = (PRBS_DEG + W - 1) / W;
  localparam int PW          = $clog2(PRIME_WORDS + 1);
  localparam int CW          = $clog2(RUN_WORDS + 1);

  typedef logic [PRBS_DEG-1:0] hist_t;

  // Shift a received word into the history; bit 0 is the earliest bit.
  function automatic hist_t load_word(hist_t h, logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      h = {h[PRBS_DEG-2:0], w[i]};
    end
    return h;
  endfunction

  // Produce the next W reference bits together with the advanced history.
  function automatic logic [PRBS_DEG+W-1:0] gen_word(hist_t h);
    logic [W-1:0] w;
    logic         nb;
    w = '0;
    for (int i = 0; i < W; i++) begin
      nb   = h[PRBS_DEG-1] ^ h[PRBS_TAP-1];
      w[i] = nb;
      h    = {h[PRBS_DEG-2:0], nb};
    end
    return {h, w};
  endfunction

  rpt_mode_e     mode;
  hist_t         hist, hist_adv, hist_ld;
  logic [PW-1:0] prime_cnt;
  logic [CW-1:0] cmp_cnt;
  logic [W-1:0]  exp_word, err_vec;
  logic          priming, comparing, word_err, sticky, sticky_nx, test_q, run_last;

  assign mode              = rpt_mode_e'(rpt_bitmode);
  assign {hist_adv, exp_word} = gen_word(hist);
  assign hist_ld           = load_word(hist, rx_data);
  assign priming           = (prime_cnt < PW'(PRIME_WORDS));
  assign comparing         = in_test && rx_vld && !priming;
  assign err_vec           = comparing ? (rx_data ^ exp_word) : '0;
  assign word_err          = |err_vec;
  assign sticky_nx         = in_test && (sticky || word_err);
  assign run_last          = (cmp_cnt == CW'(RUN_WORDS - 1));

  // Reference alignment and compare counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      prime_cnt <= '0;
      cmp_cnt   <= '0;
    end else if (!in_test) begin
      hist      <= '0;
      prime_cnt <= '0;
      cmp_cnt   <= '0;
    end else if (rx_vld) begin
      if (priming) begin
        hist      <= hist_ld;
        prime_cnt <= prime_cnt + PW'(1);
      end else begin
        hist <= hist_adv;
        if (cmp_cnt != CW'(RUN_WORDS)) cmp_cnt <= cmp_cnt + CW'(1);
      end
    end
  end

  // Sticky error and run status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      test_q   <= 1'b0;
      run_done <= 1'b0;
      run_pass <= 1'b0;
    end else begin
      sticky <= sticky_nx;
      test_q <= in_test;
      if (in_test && !test_q) begin
        run_done <= 1'b0;
        run_pass <= 1'b0;
      end else if (comparing && !run_done && run_last) begin
        run_done <= 1'b1;
        run_pass <= !(sticky || word_err);
      end
    end
  end

  // Registered outputs: pass-through or error report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data   <= '0;
      tx_vld    <= 1'b0;
      tx_lock_n <= 1'b1;
    end else begin
      tx_vld <= rx_vld;
      if (!in_test) begin
        tx_data   <= rx_data;
        tx_lock_n <= rx_lock_n;
      end else begin
        tx_lock_n <= 1'b0;
        tx_data   <= (mode == RPT_BITS) ? err_vec : {W{sticky_nx}};
      end
    end
  end
endmodule

// File: rtl/bist_multi_chk.sv
module bist_multi_chk
  import bist_chk_pkg::*;
#(
  parameter  int NCH       = 6,
  parameter  int W         = 10,
  parameter  int RUN_WORDS = 1024,
  parameter  int DEB       = 4,
  localparam int SEL_W     = $clog2(NCH + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bist_act,
  input  logic [SEL_W-1:0]   bist_sel,
  input  logic               rpt_bitmode,
  input  logic [NCH*W-1:0]   rx_data,
  input  logic [NCH-1:0]     rx_vld,
  input  logic [NCH-1:0]     rx_lock_n,
  output logic [NCH*W-1:0]   tx_data,
  output logic [NCH-1:0]     tx_vld,
  output logic [NCH-1:0]     tx_lock_n,
  output logic [2*NCH-1:0]   bist_status
);
  logic           act_on;
  logic [NCH-1:0] lane_mask;
  logic [NCH-1:0] lane_done, lane_pass;

  bist_act_filter #(.DEB(DEB)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_raw (bist_act),
    .act_on  (act_on)
  );

  bist_sel_decode #(.NCH(NCH), .SEL_W(SEL_W)) u_dec (
    .active    (act_on),
    .sel       (bist_sel),
    .lane_mask (lane_mask)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    bist_lane #(.W(W), .RUN_WORDS(RUN_WORDS)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_test     (lane_mask[g]),
      .rpt_bitmode (rpt_bitmode),
      .rx_data     (rx_data[g*W +: W]),
      .rx_vld      (rx_vld[g]),
      .rx_lock_n   (rx_lock_n[g]),
      .tx_data     (tx_data[g*W +: W]),
      .tx_vld      (tx_vld[g]),
      .tx_lock_n   (tx_lock_n[g]),
      .run_done    (lane_done[g]),
      .run_pass    (lane_pass[g])
    );
    assign bist_status[2*g+1] = lane_done[g];
    assign bist_status[2*g]   = lane_pass[g];
  end
endmodule

// File: rtl/bist_multi_chk_sva.sv
module bist_multi_chk_sva #(
  parameter int NCH = 6,
  parameter int W   = 10,
  parameter int DEB = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bist_act,
  input logic             act_on,
  input logic [NCH-1:0]   lane_mask,
  input logic             rpt_bitmode,
  input logic [NCH*W-1:0] rx_data,
  input logic [NCH*W-1:0] tx_data,
  input logic [NCH-1:0]   tx_lock_n,
  input logic [2*NCH-1:0] bist_status
);
  localparam int RW = $clog2(DEB + 1);

  logic [RW-1:0] stable_run;
  logic          act_prev;

  // Length of the current run of equal samples on the activate input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_run <= '0;
      act_prev   <= 1'b0;
    end else begin
      act_prev <= bist_act;
      if (bist_act != act_prev) stable_run <= RW'(1);
      else if (stable_run != RW'(DEB)) stable_run <= stable_run + RW'(1);
    end
  end

  // R1: the active state moves only after DEB equal samples
  p_act_debounce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on != $past(act_on)) |-> (stable_run == RW'(DEB)));

  // R2: no lane is under test while the filtered state is off
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !act_on |-> (lane_mask == '0));

  // R4: tested lanes report locked
  p_lock_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask != '0) |=> ((tx_lock_n & $past(lane_mask)) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3: lanes outside the test forward their word
    p_pass_thru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_mask[g] |=> (tx_data[g*W +: W] == $past(rx_data[g*W +: W])));

    // R6: gross report stays all ones while the lane remains under test
    p_gross_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_mask[g] && $past(lane_mask[g]) && !rpt_bitmode &&
       (tx_data[g*W +: W] == {W{1'b1}})) |=> (tx_data[g*W +: W] == {W{1'b1}}));

    // R8: pass is only ever reported together with complete
    p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bist_status[2*g] |-> bist_status[2*g+1]);

    // R8: complete holds while the lane stays under test
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_status[2*g+1] && lane_mask[g] && $past(lane_mask[g])) |=> bist_status[2*g+1]);
  end
endmodule

bind bist_multi_chk bist_multi_chk_sva #(.NCH(NCH), .W(W), .DEB(DEB)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .bist_act    (bist_act),
  .act_on      (act_on),
  .lane_mask   (lane_mask),
  .rpt_bitmode (rpt_bitmode),
  .rx_data     (rx_data),
  .tx_data     (tx_data),
  .tx_lock_n   (tx_lock_n),
  .bist_status (bist_status)
);

// File: tb/bist_multi_chk_tb_top.sv
module bist_multi_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int W   = 10;
  localparam int RUN = 8;
  localparam logic [NCH-1:0] LOCK_PAT = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             bist_act = 1'b0;
  logic [2:0]       bist_sel = 3'd7;
  logic             rpt_bitmode = 1'b0;
  logic [NCH*W-1:0] rx_data = '0;
  logic [NCH-1:0]   rx_vld = '0;
  logic [NCH-1:0]   rx_lock_n = LOCK_PAT;
  logic [NCH*W-1:0] tx_data;
  logic [NCH-1:0]   tx_vld;
  logic [NCH-1:0]   tx_lock_n;
  logic [2*NCH-1:0] bist_status;

  bist_multi_chk #(.NCH(NCH), .W(W), .RUN_WORDS(RUN), .DEB(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bist_act(bist_act), .bist_sel(bist_sel),
    .rpt_bitmode(rpt_bitmode), .rx_data(rx_data), .rx_vld(rx_vld),
    .rx_lock_n(rx_lock_n), .tx_data(tx_data), .tx_vld(tx_vld),
    .tx_lock_n(tx_lock_n), .bist_status(bist_status)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [2:0] sel;
    logic       bitmode;
    logic [2:0] elane;
    logic [4:0] eword;
    logic [9:0] emask;
  } vec_t;

  // sel, report mode, lane with injected error, valid-word index, error mask
  localparam vec_t VEC [7] = '{
    '{3'd0, 1'b0, 3'd7, 5'd0,  10'h000},
    '{3'd3, 1'b0, 3'd3, 5'd4,  10'h001},
    '{3'd6, 1'b1, 3'd5, 5'd6,  10'h2A5},
    '{3'd6, 1'b0, 3'd2, 5'd9,  10'h3FF},
    '{3'd1, 1'b0, 3'd1, 5'd10, 10'h100},
    '{3'd7, 1'b1, 3'd4, 5'd5,  10'h00F},
    '{3'd5, 1'b1, 3'd0, 5'd3,  10'h0F0}
  };

  logic [14:0] bh [NCH];
  bit exp_done [NCH];
  bit exp_pass [NCH];

  // Reference generator written from R5: new bit = s[k-15] xor s[k-14], bit 0 first
  function automatic logic [W+14:0] prbs_word(input logic [14:0] h);
    logic [W-1:0] w;
    logic b;
    for (int i = 0; i < W; i++) begin
      b = h[14] ^ h[13];
      w[i] = b;
      h = {h[13:0], b};
    end
    return {h, w};
  endfunction

  function automatic logic [2*NCH-1:0] packed_status();
    logic [2*NCH-1:0] s;
    for (int l = 0; l < NCH; l++) begin
      s[2*l+1] = exp_done[l];
      s[2*l]   = exp_pass[l];
    end
    return s;
  endfunction

  function automatic bit tested(input logic [2:0] sel, input int l);
    return (sel == 3'(l)) || (sel == 3'd6);
  endfunction

  task automatic activate(input logic [2:0] sel, input logic mode);
    bist_sel = sel;
    rpt_bitmode = mode;
    rx_vld = '0;
    bist_act = 1'b1;
    repeat (3) cyc();
    chk(tx_lock_n == rx_lock_n, "R1 three samples must not activate", tx_lock_n, rx_lock_n);
    cyc();
  endtask

  task automatic run_entry(input vec_t v, input int e);
    int widx = 0;
    int slot = 0;
    bit gset [NCH];
    logic [2*NCH-1:0] tmask = '0;
    activate(v.sel, v.bitmode);
    for (int l = 0; l < NCH; l++) begin
      gset[l] = 1'b0;
      bh[l] = 15'h0001 + 15'(l) * 15'h0F1D;
      if (tested(v.sel, l)) begin
        exp_done[l] = 1'b0;
        exp_pass[l] = 1'b0;
        tmask[2*l+1 -: 2] = 2'b11;
      end
    end
    while (widx < 12) begin
      logic vld;
      logic [W-1:0] d [NCH];
      bit inj [NCH];
      logic [W+14:0] r;
      vld = (slot % 4) != 3;
      for (int l = 0; l < NCH; l++) begin
        inj[l] = 1'b0;
        if (vld) begin
          r = prbs_word(bh[l]);
          bh[l] = r[W+14:W];
          inj[l] = (l == int'(v.elane)) && (widx == int'(v.eword));
          d[l] = r[W-1:0] ^ (inj[l] ? v.emask : 10'h000);
        end else begin
          d[l] = 10'h155 ^ 10'(l);
        end
        rx_data[l*W +: W] = d[l];
      end
      rx_vld = {NCH{vld}};
      cyc();
      for (int l = 0; l < NCH; l++) begin
        logic [W-1:0] expd;
        bit cmpw;
        chk(tx_vld[l] == vld, "R3 valid delay", tx_vld[l], vld);
        if (tested(v.sel, l)) begin
          chk(tx_lock_n[l] == 1'b0, "R4 lock forced", tx_lock_n[l], 0);
          cmpw = vld && (widx >= 2);
          if (inj[l] && cmpw) gset[l] = 1'b1;
          if (v.bitmode) begin
            expd = (inj[l] && cmpw) ? v.emask : 10'h000;
            if (vld && widx < 2) chk(tx_data[l*W +: W] == expd, "R5 priming word", tx_data[l*W +: W], expd);
            else chk(tx_data[l*W +: W] == expd, "R7 bit report", tx_data[l*W +: W], expd);
          end else begin
            expd = gset[l] ? 10'h3FF : 10'h000;
            chk(tx_data[l*W +: W] == expd, "R6 gross report", tx_data[l*W +: W], expd);
          end
        end else begin
          chk(tx_data[l*W +: W] == d[l], "R3 data pass", tx_data[l*W +: W], d[l]);
          chk(tx_lock_n[l] == rx_lock_n[l], "R3 lock pass", tx_lock_n[l], rx_lock_n[l]);
        end
      end
      if (slot == 0)
        chk((bist_status & tmask) == '0, "R10 clear on entry", bist_status & tmask, 0);
      if (vld) widx++;
      slot++;
    end
    for (int l = 0; l < NCH; l++) begin
      if (tested(v.sel, l)) begin
        exp_done[l] = 1'b1;
        exp_pass[l] = !((l == int'(v.elane)) && (v.eword >= 5'd2) && (v.eword <= 5'd9));
      end
    end
    chk(bist_status == packed_status(), "R8 status after run", bist_status, packed_status());
    if (e == 1) chk(bist_status[7:6] == 2'b10, "R9 lane3 pair position", bist_status[7:6], 2'b10);
    if (e == 5) chk(tx_lock_n == rx_lock_n, "R12 code 7 idle", tx_lock_n, rx_lock_n);
    bist_act = 1'b0;
    rx_vld = '0;
    repeat (5) cyc();
    chk(bist_status == packed_status(), "R10 status kept", bist_status, packed_status());
    chk(tx_lock_n == rx_lock_n, "R2 idle after stop", tx_lock_n, rx_lock_n);
  endtask

  initial begin
    for (int l = 0; l < NCH; l++) begin
      exp_done[l] = 1'b0;
      exp_pass[l] = 1'b0;
    end
    repeat (3) cyc();
    chk(tx_lock_n == '1, "R11 reset lock", tx_lock_n, 6'h3F);
    chk(tx_data == '0, "R11 reset data", tx_data, 0);
    chk(bist_status == '0 && tx_vld == '0, "R11 reset status", bist_status, 0);
    rst_n = 1'b1;
    cyc();

    // Short activate pulse with the all-lanes code must be ignored
    bist_sel = 3'd6;
    bist_act = 1'b1;
    repeat (3) cyc();
    bist_act = 1'b0;
    repeat (2) cyc();
    chk(tx_lock_n == rx_lock_n, "R1 glitch ignored", tx_lock_n, rx_lock_n);
    repeat (4) cyc();
    chk(tx_lock_n == rx_lock_n, "R2 act low idle", tx_lock_n, rx_lock_n);

    for (int e = 0; e < 7; e++) run_entry(VEC[e], e);

    // Short dropout of the activate level must not stop a running test
    activate(3'd4, 1'b0);
    cyc();
    chk(tx_lock_n[4] == 1'b0, "R12 single lane 4", tx_lock_n[4], 0);
    chk(tx_lock_n[3] == rx_lock_n[3], "R12 lane 3 untouched", tx_lock_n[3], rx_lock_n[3]);
    bist_act = 1'b0;
    repeat (3) cyc();
    bist_act = 1'b1;
    repeat (2) cyc();
    chk(tx_lock_n[4] == 1'b0, "R1 dropout ignored", tx_lock_n[4], 0);
    bist_act = 1'b0;
    repeat (4) cyc();
    chk(tx_lock_n[4] == 1'b0, "R1 off takes effect at fourth edge", tx_lock_n[4], 0);
    cyc();
    chk(tx_lock_n[4] == rx_lock_n[4], "R1 off after four samples", tx_lock_n[4], rx_lock_n[4]);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule